// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen general registers of a processor core, plus the saved status word. Some of these registers have a private copy for each operating mode. The stack pointer (r13), the link register (r14) and the saved status word live in one bank per privilege context. The fast-interrupt mode also has its own copies of r8 through r12. The core reads the file through two combinational read ports. It writes one register per clock through a single write port, addressed by logical register numbers 0 to 15. The status word has its own write strobe and read bus.

The core changes mode by raising a request with the target mode encoding. On the next clock edge the file does three things at once:

- It saves the live copies that belong to the outgoing mode.
- It loads the copies that belong to the incoming mode.
- It updates the current-mode output.

The core therefore always addresses registers by their logical number and never has to know which physical copy it reaches. A request naming an encoding that is not a valid mode is refused. The refusal is reported on a one-cycle flag.

Top module: `banked_regfile`

## Requirements
- R1: After reset the current mode is supervisor (5'b10011), every register r0 to r15 in every bank and the saved status word read zero, and the bad-mode flag is low.
- R2: Both read ports return the addressed register combinationally. A write with `wr_en` high is visible on the read ports from the cycle after its clock edge.
- R3: Mode codes are user 5'b10000, fast-interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011 and system 5'b11111. A request with a legal code changes `cur_mode` at the next clock edge. Reads in the cycle of the request return the values from before the switch.
- R4: Supervisor, abort, undefined, interrupt, fast-interrupt and the user/system pair each keep their own r13, r14 and saved status word. A value written in one bank is not seen from another bank and is found again when that bank's mode returns.
- R5: User and system modes share one bank: r13, r14 and the saved status word written in one are read back in the other.
- R6: Entering fast-interrupt mode exposes its own r8 to r12. Leaving it restores the r8 to r12 that every other mode shares, and keeps the fast-interrupt copies for the next entry.
- R7: r0 to r7 and r15 are shared by all modes, and r8 to r12 are shared by all modes except fast-interrupt.
- R8: A request whose target equals the current mode changes no register, leaves the mode as it is and does not raise the bad-mode flag.
- R9: A request with any other code leaves the mode and all registers unchanged and drives `bad_mode` high for exactly the following cycle.
- R10: A register write in the same cycle as a mode request lands in the outgoing mode's copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | Request a mode change this cycle |
| mode_new | input | 5 | Target mode code |
| cur_mode | output | 5 | Current mode code |
| bad_mode | output | 1 | Previous cycle's request carried an illegal code |
| ra_addr | input | 4 | Read port A register number |
| ra_data | output | DW | Read port A data |
| rb_addr | input | 4 | Read port B register number |
| rb_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Write register number |
| wr_data | input | DW | Write data |
| spsr_we | input | 1 | Saved status word write enable |
| spsr_wdata | input | DW | Saved status word write data |
| spsr_rdata | output | DW | Saved status word of the current bank |

## Verification
Two kinds of internal fault show up at the ports only when a mode comes back:

- If a swap saves into the wrong bank, or loads from the wrong shadow, the damage stays hidden until the core returns to the mode that owns the misplaced value. It then shows as a wrong r13, r14, saved status word or r8 to r12 on the first read after the return edge.
- If two modes are mapped to one bank, the fault shows only when both modes have been written and one of them is revisited.

The stimulus therefore tours every bank and comes back to it with distinct values. It passes through user and system back to back. It enters and leaves fast-interrupt twice. A corrupted mode register appears on `cur_mode` one cycle after the request.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_req,
  input  logic [4:0]    mode_new,
  output logic [4:0]    cur_mode,
  output logic          bad_mode,
  input  logic [3:0]    ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          spsr_we,
  input  logic [DW-1:0] spsr_wdata,
  output logic [DW-1:0] spsr_rdata
);
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;
  localparam int NREG  = 16;
  localparam int NBANK = 6;
  localparam int HI_LO = 8;
  localparam int HI_N  = 5;
  localparam int SP    = 13;
  localparam int LR    = 14;

  function automatic logic mode_ok(input logic [4:0] m);
    return (m == M_USR) || (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND) || (m == M_SYS);
  endfunction

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_SVC:   return 3'd1;
      M_ABT:   return 3'd2;
      M_UND:   return 3'd3;
      M_IRQ:   return 3'd4;
      M_FIQ:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  logic [DW-1:0] gpr   [NREG];
  logic [DW-1:0] usr_hi[HI_N];
  logic [DW-1:0] fiq_hi[HI_N];
  logic [DW-1:0] bk_sp [NBANK];
  logic [DW-1:0] bk_lr [NBANK];
  logic [DW-1:0] bk_psr[NBANK];
  logic [DW-1:0] spsr;

  logic [DW-1:0] gpr_n   [NREG];
  logic [DW-1:0] usr_hi_n[HI_N];
  logic [DW-1:0] fiq_hi_n[HI_N];
  logic [DW-1:0] bk_sp_n [NBANK];
  logic [DW-1:0] bk_lr_n [NBANK];
  logic [DW-1:0] bk_psr_n[NBANK];
  logic [DW-1:0] spsr_n;

  wire       req_ok = mode_req && mode_ok(mode_new);
  wire       swap   = req_ok && (mode_new != cur_mode);
  wire [2:0] b_out  = bank_of(cur_mode);
  wire [2:0] b_in   = bank_of(mode_new);

  assign ra_data    = gpr[ra_addr];
  assign rb_data    = gpr[rb_addr];
  assign spsr_rdata = spsr;

  always_comb begin
    gpr_n    = gpr;
    usr_hi_n = usr_hi;
    fiq_hi_n = fiq_hi;
    bk_sp_n  = bk_sp;
    bk_lr_n  = bk_lr;
    bk_psr_n = bk_psr;
    spsr_n   = spsr;
    if (wr_en)   gpr_n[wr_addr] = wr_data;
    if (spsr_we) spsr_n = spsr_wdata;
    if (swap) begin
      if (cur_mode == M_FIQ) begin
        for (int i = 0; i < HI_N; i++) begin
          fiq_hi_n[i]       = gpr_n[HI_LO+i];
          gpr_n[HI_LO+i]    = usr_hi[i];
        end
      end else if (mode_new == M_FIQ) begin
        for (int i = 0; i < HI_N; i++) begin
          usr_hi_n[i]       = gpr_n[HI_LO+i];
          gpr_n[HI_LO+i]    = fiq_hi[i];
        end
      end
      bk_sp_n[b_out]  = gpr_n[SP];
      bk_lr_n[b_out]  = gpr_n[LR];
      bk_psr_n[b_out] = spsr_n;
      gpr_n[SP] = bk_sp_n[b_in];
      gpr_n[LR] = bk_lr_n[b_in];
      spsr_n    = bk_psr_n[b_in];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
      for (int i = 0; i < HI_N; i++) begin
        usr_hi[i] <= '0;
        fiq_hi[i] <= '0;
      end
      for (int i = 0; i < NBANK; i++) begin
        bk_sp[i]  <= '0;
        bk_lr[i]  <= '0;
        bk_psr[i] <= '0;
      end
      spsr     <= '0;
      cur_mode <= M_SVC;
      bad_mode <= 1'b0;
    end else begin
      gpr      <= gpr_n;
      usr_hi   <= usr_hi_n;
      fiq_hi   <= fiq_hi_n;
      bk_sp    <= bk_sp_n;
      bk_lr    <= bk_lr_n;
      bk_psr   <= bk_psr_n;
      spsr     <= spsr_n;
      bad_mode <= mode_req && !mode_ok(mode_new);
      if (swap) cur_mode <= mode_new;
    end
  end

  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok(cur_mode));

  assert_switch_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |=> cur_mode == $past(mode_new));

  assert_bad_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req && !mode_ok(mode_new) |=> bad_mode && $stable(cur_mode));

  assert_bad_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> $past(mode_req) && !mode_ok($past(mode_new)));

  assert_same_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req && mode_new == cur_mode && !wr_en && !spsr_we
    |=> $stable(spsr) && $stable(gpr[SP]) && $stable(gpr[LR]) && $stable(gpr[HI_LO]));

  assert_low_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req && !wr_en |=> $stable(gpr[0]) && $stable(gpr[7]) && $stable(gpr[15]));
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int DW = 32;
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;
  localparam logic [2:0] OP_WR = 3'd0;
  localparam logic [2:0] OP_MD = 3'd1;
  localparam logic [2:0] OP_CR = 3'd2;
  localparam logic [2:0] OP_WS = 3'd3;
  localparam logic [2:0] OP_CS = 3'd4;
  localparam logic [2:0] OP_CM = 3'd5;
  localparam int NV = 60;

  localparam logic [43:0] VEC [NV] = '{
    {OP_WR, 5'd13,  32'h0000_0A13, 4'd4},
    {OP_WR, 5'd14,  32'h0000_0A14, 4'd4},
    {OP_WS, 5'd0,   32'h0000_005A, 4'd4},
    {OP_WR, 5'd8,   32'h0000_0088, 4'd7},
    {OP_WR, 5'd0,   32'h0000_0100, 4'd7},
    {OP_MD, M_IRQ,  32'h0,         4'd3},
    {OP_CM, 5'd0,   {27'd0, M_IRQ}, 4'd3},    // R3
    {OP_CR, 5'd13,  32'h0,         4'd4},     // R4
    {OP_CR, 5'd8,   32'h0000_0088, 4'd7},     // R7
    {OP_CR, 5'd0,   32'h0000_0100, 4'd7},     // R7
    {OP_WR, 5'd13,  32'h0000_0B13, 4'd4},
    {OP_WS, 5'd0,   32'h0000_006B, 4'd4},
    {OP_MD, M_FIQ,  32'h0,         4'd6},
    {OP_CR, 5'd8,   32'h0,         4'd6},     // R6
    {OP_CR, 5'd13,  32'h0,         4'd4},     // R4
    {OP_WR, 5'd8,   32'h0000_00F8, 4'd6},
    {OP_WR, 5'd12,  32'h0000_00FC, 4'd6},
    {OP_WR, 5'd13,  32'h0000_0F13, 4'd4},
    {OP_CR, 5'd0,   32'h0000_0100, 4'd7},     // R7
    {OP_MD, M_USR,  32'h0,         4'd6},
    {OP_CR, 5'd8,   32'h0000_0088, 4'd6},     // R6
    {OP_CR, 5'd12,  32'h0,         4'd6},     // R6
    {OP_CR, 5'd13,  32'h0,         4'd4},     // R4
    {OP_WR, 5'd13,  32'h0000_0513, 4'd5},
    {OP_WR, 5'd14,  32'h0000_0514, 4'd5},
    {OP_WS, 5'd0,   32'h0000_0077, 4'd5},
    {OP_MD, M_SYS,  32'h0,         4'd5},
    {OP_CR, 5'd13,  32'h0000_0513, 4'd5},     // R5
    {OP_CR, 5'd14,  32'h0000_0514, 4'd5},     // R5
    {OP_CS, 5'd0,   32'h0000_0077, 4'd5},     // R5
    {OP_MD, M_FIQ,  32'h0,         4'd6},
    {OP_CR, 5'd8,   32'h0000_00F8, 4'd6},     // R6
    {OP_CR, 5'd12,  32'h0000_00FC, 4'd6},     // R6
    {OP_CR, 5'd13,  32'h0000_0F13, 4'd4},     // R4
    {OP_WR, 5'd15,  32'h0000_0015, 4'd7},
    {OP_MD, M_SVC,  32'h0,         4'd4},
    {OP_CR, 5'd13,  32'h0000_0A13, 4'd4},     // R4
    {OP_CR, 5'd14,  32'h0000_0A14, 4'd4},     // R4
    {OP_CS, 5'd0,   32'h0000_005A, 4'd4},     // R4
    {OP_CR, 5'd8,   32'h0000_0088, 4'd6},     // R6
    {OP_CR, 5'd15,  32'h0000_0015, 4'd7},     // R7
    {OP_MD, M_IRQ,  32'h0,         4'd4},
    {OP_CR, 5'd13,  32'h0000_0B13, 4'd4},     // R4
    {OP_CS, 5'd0,   32'h0000_006B, 4'd4},     // R4
    {OP_MD, M_ABT,  32'h0,         4'd4},
    {OP_CR, 5'd13,  32'h0,         4'd4},     // R4
    {OP_WR, 5'd13,  32'h0000_00AB, 4'd4},
    {OP_MD, M_UND,  32'h0,         4'd4},
    {OP_CR, 5'd13,  32'h0,         4'd4},     // R4
    {OP_WR, 5'd13,  32'h0000_00DD, 4'd4},
    {OP_MD, M_ABT,  32'h0,         4'd4},
    {OP_CR, 5'd13,  32'h0000_00AB, 4'd4},     // R4
    {OP_MD, M_USR,  32'h0,         4'd5},
    {OP_CR, 5'd13,  32'h0000_0513, 4'd5},     // R5
    {OP_MD, M_FIQ,  32'h0,         4'd6},
    {OP_CR, 5'd8,   32'h0000_00F8, 4'd6},     // R6
    {OP_CR, 5'd0,   32'h0000_0100, 4'd7},     // R7
    {OP_MD, M_UND,  32'h0,         4'd6},
    {OP_CR, 5'd12,  32'h0,         4'd6},     // R6
    {OP_CR, 5'd13,  32'h0000_00DD, 4'd4}      // R4
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_req;
  logic [4:0]    mode_new;
  logic [4:0]    cur_mode;
  logic          bad_mode;
  logic [3:0]    ra_addr, rb_addr, wr_addr;
  logic [DW-1:0] ra_data, rb_data, wr_data, spsr_wdata, spsr_rdata;
  logic          wr_en, spsr_we;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  banked_regfile #(.DW(DW)) u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_new(mode_new),
    .cur_mode(cur_mode), .bad_mode(bad_mode), .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    mode_req = 1'b0; mode_new = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    spsr_we = 1'b0; spsr_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [DW-1:0] exp, input string req);
    ra_addr = a;
    #1;
    chk(req, ra_data, exp);
  endtask

  initial begin
    idle();
    ra_addr = '0; rb_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      ra_addr = 4'(i);
      rb_addr = 4'(15 - i);
      #1;
      chk("R1 port A", ra_data, '0);
      chk("R1 port B", rb_data, '0);
    end
    chk("R1 mode", {27'd0, cur_mode}, {27'd0, M_SVC});
    chk("R1 spsr", spsr_rdata, '0);
    chk("R1 bad", {31'd0, bad_mode}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]    op;
      logic [4:0]    a;
      logic [DW-1:0] d;
      logic [3:0]    r;
      string         tag;
      @(negedge clk);
      idle();
      op = VEC[i][43:41]; a = VEC[i][40:36]; d = VEC[i][35:4]; r = VEC[i][3:0];
      tag = $sformatf("R%0d vec %0d", r, i);
      case (op)
        OP_WR: begin wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d; end
        OP_MD: begin mode_req = 1'b1; mode_new = a; end
        OP_CR: rd(a[3:0], d, tag);
        OP_WS: begin spsr_we = 1'b1; spsr_wdata = d; end
        OP_CS: chk(tag, spsr_rdata, d);
        default: chk(tag, {27'd0, cur_mode}, d);
      endcase
    end
    @(negedge clk);
    idle();

    // R3: same-cycle read returns pre-switch value (mode is UND, r13 = DD)
    mode_req = 1'b1; mode_new = M_SVC;
    rd(4'd13, 32'h0000_00DD, "R3 same-cycle read");
    @(negedge clk);
    idle();
    rd(4'd13, 32'h0000_0A13, "R3 post-switch r13");
    chk("R3 mode", {27'd0, cur_mode}, {27'd0, M_SVC});

    // R8: same-mode request
    @(negedge clk);
    mode_req = 1'b1; mode_new = M_SVC;
    @(negedge clk);
    idle();
    rd(4'd13, 32'h0000_0A13, "R8 r13");
    chk("R8 spsr", spsr_rdata, 32'h0000_005A);
    chk("R8 mode", {27'd0, cur_mode}, {27'd0, M_SVC});
    chk("R8 bad", {31'd0, bad_mode}, '0);

    // R9: illegal codes
    @(negedge clk);
    mode_req = 1'b1; mode_new = 5'b10100;
    @(negedge clk);
    idle();
    chk("R9 bad high", {31'd0, bad_mode}, 32'd1);
    chk("R9 mode kept", {27'd0, cur_mode}, {27'd0, M_SVC});
    rd(4'd13, 32'h0000_0A13, "R9 r13 kept");
    @(negedge clk);
    chk("R9 bad one cycle", {31'd0, bad_mode}, '0);
    mode_req = 1'b1; mode_new = 5'b00011;
    @(negedge clk);
    idle();
    chk("R9 bad high code 00011", {31'd0, bad_mode}, 32'd1);
    chk("R9 spsr kept", spsr_rdata, 32'h0000_005A);
    chk("R9 mode kept 2", {27'd0, cur_mode}, {27'd0, M_SVC});

    // R10: write in the switch cycle goes to the outgoing mode
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd14; wr_data = 32'h0000_0C14;
    mode_req = 1'b1; mode_new = M_ABT;
    @(negedge clk);
    idle();
    rd(4'd14, 32'h0, "R10 abort r14");
    @(negedge clk);
    mode_req = 1'b1; mode_new = M_SVC;
    @(negedge clk);
    idle();
    rd(4'd14, 32'h0000_0C14, "R10 supervisor r14");

    // R2: two read ports and write latency
    ra_addr = 4'd13; rb_addr = 4'd14;
    #1;
    chk("R2 port A", ra_data, 32'h0000_0A13);
    chk("R2 port B", rb_data, 32'h0000_0C14);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'hDEAD_BEEF;
    rb_addr = 4'd3;
    #1;
    chk("R2 before edge", rb_data, 32'h0);
    @(negedge clk);
    idle();
    chk("R2 after edge", rb_data, 32'hDEAD_BEEF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule